// File: doc/BRIEF.md
# Seven-to-one multi-lane serializer

This block turns a 21-bit parallel word into three serial data lanes and one forwarded-clock lane. A word is registered on each rising edge of a slow word clock. A bit clock that runs at exactly seven times that rate shifts the word out. The word is cut into three 7-bit slices, one per lane, and one word leaves in seven bit-clock cycles. The clock lane carries a fixed 7-bit pattern in every frame, so its rising edge marks a known bit position. A receiver can use it to find frame boundaries.

The block does not multiply clocks. The bit clock comes from outside, with a one-cycle frame strobe in the bit-clock domain. The shift registers reload from the registered word only on that strobe. The integrator must time the strobe well away from the word-clock edge, so no metastable transfer happens between the two domains. An active-low shutdown input clears every register in both domains and idles all four lanes. After shutdown is released, the lanes stay at zero until a first word has been registered and loaded.

Top module: `ser7_lane_tx`

## Requirements
- R1: `din` is sampled only on the rising edge of `clk_word`. A change of `din` while `clk_word` is high, after that edge, does not appear on any lane.
- R2: Once loaded, a word occupies exactly seven consecutive `clk_bit` cycles, one bit per lane per cycle. Every word sampled with `shdn_n` high and loaded by a strobe is sent once, in the order the words were sampled.
- R3: Word bits 0 to 6 go to `lane_data[0]`, bits 7 to 13 to `lane_data[1]`, and bits 14 to 20 to `lane_data[2]`.
- R4: Within each lane the lowest-numbered bit of the slice is sent first. It appears in the `clk_bit` cycle right after the edge that samples `frame_start` high.
- R5: In each frame `lane_clk` sends the sequence 1,1,0,0,0,1,1 (slot 0 first). During continuous frames its only rising edge is at slot 5.
- R6: The shift registers load only on a `clk_bit` edge that samples `frame_start` high. If no strobe follows the seventh bit, all four lanes output 0 until the next strobe.
- R7: While `shdn_n` is low, every register is cleared. All lanes are 0 from the first `clk_bit` edge that samples it low, and no part of an interrupted word is sent later.
- R8: After `shdn_n` rises, all lanes stay 0 until a strobe loads a word sampled on a `clk_word` edge with `shdn_n` high. A strobe before such a word loads zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_word | input | 1 | Word clock; `din` sampled on its rising edge |
| clk_bit | input | 1 | Bit clock, seven times the word-clock rate |
| shdn_n | input | 1 | Active-low shutdown and synchronous clear, both domains |
| frame_start | input | 1 | One-cycle frame strobe in the `clk_bit` domain |
| din | input | 21 | Parallel data word |
| lane_data | output | 3 | Serial data lanes, bit i carries slice i |
| lane_clk | output | 1 | Forwarded clock lane, one period per frame |

## Verification
A walking single one across all 21 bits pins each bit to one lane and one slot, so it separates a lane-mapping fault from a bit-order fault. Alternating, all-ones, all-zeros, counting and random words exercise neighbouring bits and full shift chains. After each slow edge the input is overwritten with its complement, so a design that samples at the wrong moment shows inverted data. Gaps in the strobe, a shutdown in mid-frame and a release before a valid word check that the lanes drain to zero and that an interrupted word never reappears. The bench also recovers words from the lanes using the clock-lane pattern and compares them, in order, with the words that were applied.

// File: rtl/ser7_pkg.sv
// Package ser7_pkg
// Purpose : shared defaults and a helper for the seven-to-one serializer.
// Assumes : patterns are no wider than 32 bits.
package ser7_pkg;

    localparam int unsigned DEF_SLICE_W = 7;
    localparam int unsigned DEF_LANES   = 3;

    // Slot index of the first 0->1 transition inside a clock-lane pattern
    // (slot 0 is sent first); returns 0 when there is none.
    function automatic int unsigned rise_slot(input logic [31:0] pat, input int unsigned w);
        int unsigned found;
        found = 0;
        for (int unsigned i = 1; i < 32; i++) begin
            if (i < w && found == 0 && pat[i] && !pat[i-1]) begin
                found = i;
            end
        end
        return found;
    endfunction

endpackage

// File: rtl/ser7_word_capture.sv
// Module ser7_word_capture
// Purpose : registers the parallel word on the word clock and flags that a
//           word taken with shutdown released is held.
// Assumes : shdn_n acts as a synchronous active-low clear in this domain.
module ser7_word_capture #(
    parameter int unsigned WORD_W = 21
) (
    input  logic              clk_word,
    input  logic              shdn_n,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] cap_word,
    output logic              cap_valid
);

    // Sample the word on every word-clock edge; clear on shutdown.
    always_ff @(posedge clk_word) begin
        if (!shdn_n) begin
            cap_word  <= '0;
            cap_valid <= 1'b0;
        end else begin
            cap_word  <= din;
            cap_valid <= 1'b1;
        end
    end

endmodule

// File: rtl/ser7_frame_ctrl.sv
// Module ser7_frame_ctrl
// Purpose : tracks which slot of the frame is on the lanes and whether a
//           valid frame is being sent.
// Assumes : while a frame is active, frame_start comes exactly at the last
//           slot; word_valid is stable around the strobe edge.
module ser7_frame_ctrl #(
    parameter int unsigned SLICE_W = 7,
    localparam int unsigned IDX_W  = (SLICE_W > 1) ? $clog2(SLICE_W) : 1
) (
    input  logic             clk_bit,
    input  logic             shdn_n,
    input  logic             frame_start,
    input  logic             word_valid,
    output logic [IDX_W-1:0] bit_idx,
    output logic             active
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(SLICE_W - 1);

    // Restart the slot count on a strobe, step it while a frame runs.
    always_ff @(posedge clk_bit) begin
        if (!shdn_n) begin
            bit_idx <= '0;
            active  <= 1'b0;
        end else if (frame_start) begin
            bit_idx <= '0;
            active  <= word_valid;
        end else if (active) begin
            if (bit_idx == LAST) begin
                bit_idx <= '0;
                active  <= 1'b0;
            end else begin
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    // R2: a strobe during a running frame must come at its last slot.
    p_strobe_cadence_r2: assert property (@(posedge clk_bit) disable iff (!shdn_n)
        (frame_start && active) |-> (bit_idx == LAST));

    // R8: a strobe with no valid word leaves the lanes idle.
    p_idle_without_word_r8: assert property (@(posedge clk_bit) disable iff (!shdn_n)
        (frame_start && !word_valid) |=> !active);

endmodule

// File: rtl/ser7_lane_shifter.sv
// Module ser7_lane_shifter
// Purpose : parallel-load, serial-out shift register for one lane; bit 0 of
//           the loaded slice leaves first, zeros fill from the top.
// Assumes : load is a single-cycle pulse in the clk_bit domain.
module ser7_lane_shifter #(
    parameter int unsigned WIDTH = 7
) (
    input  logic             clk_bit,
    input  logic             shdn_n,
    input  logic             load,
    input  logic [WIDTH-1:0] par,
    output logic             ser
);

    logic [WIDTH-1:0] sreg;

    // Load the slice on a strobe, otherwise shift one place toward bit 0.
    always_ff @(posedge clk_bit) begin
        if (!shdn_n) begin
            sreg <= '0;
        end else if (load) begin
            sreg <= par;
        end else begin
            sreg <= {1'b0, sreg[WIDTH-1:1]};
        end
    end

    assign ser = sreg[0];

    // R4: the first slot after a load carries bit 0 of the loaded slice.
    p_first_bit_r4: assert property (@(posedge clk_bit) disable iff (!shdn_n)
        load |=> (ser == $past(par[0])));

    // R6: without a load the register only drains, it never gains ones.
    p_drain_only_r6: assert property (@(posedge clk_bit) disable iff (!shdn_n)
        !load |=> ($countones(sreg) <= $past($countones(sreg))));

endmodule

// File: rtl/ser7_lane_tx.sv
// Module ser7_lane_tx
// Purpose : top of the seven-to-one serializer. It registers a word on the
//           word clock, slices it over the data lanes and sends a fixed
//           clock pattern on the forwarded-clock lane, one frame per strobe.
// Assumes : clk_bit runs at SLICE_W times clk_word; frame_start is placed
//           well clear of the clk_word rising edge; shdn_n is held low for
//           at least one edge of each clock.
module ser7_lane_tx #(
    parameter int unsigned          LANES       = ser7_pkg::DEF_LANES,
    parameter int unsigned          SLICE_W     = ser7_pkg::DEF_SLICE_W,
    parameter logic [SLICE_W-1:0]   CLK_PATTERN = 7'b1100011,
    localparam int unsigned         WORD_W      = LANES * SLICE_W,
    localparam int unsigned         IDX_W       = (SLICE_W > 1) ? $clog2(SLICE_W) : 1
) (
    input  logic              clk_word,
    input  logic              clk_bit,
    input  logic              shdn_n,
    input  logic              frame_start,
    input  logic [WORD_W-1:0] din,
    output logic [LANES-1:0]  lane_data,
    output logic              lane_clk
);

    localparam int unsigned RISE_POS = ser7_pkg::rise_slot(32'(CLK_PATTERN), SLICE_W);

    logic [WORD_W-1:0]  cap_word;
    logic               cap_valid;
    logic [IDX_W-1:0]   bit_idx;
    logic               frame_active;
    logic [SLICE_W-1:0] clk_par;

    // Word-clock side: parallel capture.
    ser7_word_capture #(.WORD_W(WORD_W)) u_capture (
        .clk_word  (clk_word),
        .shdn_n    (shdn_n),
        .din       (din),
        .cap_word  (cap_word),
        .cap_valid (cap_valid)
    );

    // Bit-clock side: frame position tracking.
    ser7_frame_ctrl #(.SLICE_W(SLICE_W)) u_frame (
        .clk_bit     (clk_bit),
        .shdn_n      (shdn_n),
        .frame_start (frame_start),
        .word_valid  (cap_valid),
        .bit_idx     (bit_idx),
        .active      (frame_active)
    );

    // One shifter per data lane, fed its slice or zeros when no word is held.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [SLICE_W-1:0] slice;

        // Pick the slice of this lane, or zeros before a valid word.
        always_comb begin
            slice = cap_valid ? cap_word[g*SLICE_W +: SLICE_W] : '0;
        end

        ser7_lane_shifter #(.WIDTH(SLICE_W)) u_shift (
            .clk_bit (clk_bit),
            .shdn_n  (shdn_n),
            .load    (frame_start),
            .par     (slice),
            .ser     (lane_data[g])
        );
    end

    // Clock-lane pattern is sent only alongside a valid word.
    always_comb begin
        clk_par = cap_valid ? CLK_PATTERN : '0;
    end

    ser7_lane_shifter #(.WIDTH(SLICE_W)) u_clk_shift (
        .clk_bit (clk_bit),
        .shdn_n  (shdn_n),
        .load    (frame_start),
        .par     (clk_par),
        .ser     (lane_clk)
    );

    // R7: one edge after shutdown is seen, every lane is idle.
    p_shutdown_idle_r7: assert property (@(posedge clk_bit)
        !shdn_n |=> ((lane_data == '0) && !lane_clk));

    // R5: inside a frame, the clock lane rises only at its marker slot.
    p_clk_rise_slot_r5: assert property (@(posedge clk_bit) disable iff (!shdn_n)
        ($rose(lane_clk) && (bit_idx != '0)) |-> (bit_idx == IDX_W'(RISE_POS)));

    // R6: lanes carry data only while a frame is active.
    p_idle_out_of_frame_r6: assert property (@(posedge clk_bit) disable iff (!shdn_n)
        !frame_active |-> ((lane_data == '0) && !lane_clk));

endmodule

// File: tb/tb_ser7_lane_tx.sv
`timescale 1ns/1ps
// Bench for ser7_lane_tx: behavioural per-cycle model plus a deserializer
// that aligns on the clock-lane pattern.
module tb_ser7_lane_tx;

    logic        clk_bit = 1'b0;
    logic        clk_word = 1'b0;
    logic        shdn_n = 1'b0;
    logic        frame_start = 1'b0;
    logic [20:0] din = '0;
    logic [2:0]  lane_data;
    logic        lane_clk;

    ser7_lane_tx dut (
        .clk_word    (clk_word),
        .clk_bit     (clk_bit),
        .shdn_n      (shdn_n),
        .frame_start (frame_start),
        .din         (din),
        .lane_data   (lane_data),
        .lane_clk    (lane_clk)
    );

    always #2.5 clk_bit = ~clk_bit;   // 200 MHz bit clock

    int          n_cmp = 0;
    int          n_bad = 0;
    int          ph = 0;
    int          pos = -1;
    int          n_rx = 0;
    bit          done = 1'b0;
    bit          strobe_en = 1'b1;
    bit          shdn_req = 1'b0;
    bit          m_valid = 1'b0;
    logic [20:0] word_in = '0;
    logic [20:0] m_cap = '0;
    logic [20:0] m_cur = '0;
    logic [20:0] sent[$];
    logic [6:0]  h_clk = '0;
    logic [6:0]  h_l0 = '0;
    logic [6:0]  h_l1 = '0;
    logic [6:0]  h_l2 = '0;
    string       cur_req = "R7";

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // One bit-clock cycle: sample, drive at the falling edge, then model the next rising edge.
    task automatic step();
        logic [20:0] got;
        logic [20:0] want;
        @(negedge clk_bit);
        for (int l = 0; l < 3; l++) begin
            chk(32'(lane_data[l]), (pos < 0) ? 32'd0 : 32'(m_cur[7*l + pos]), cur_req, $sformatf("lane %0d", l));
        end
        // R5: clock lane sends 1,1,0,0,0,1,1 by slot.
        chk(32'(lane_clk), (pos < 0) ? 32'd0 : ((pos < 2 || pos > 4) ? 32'd1 : 32'd0), "R5", "clock lane");
        h_clk = {lane_clk, h_clk[6:1]};
        h_l0  = {lane_data[0], h_l0[6:1]};
        h_l1  = {lane_data[1], h_l1[6:1]};
        h_l2  = {lane_data[2], h_l2[6:1]};
        if (h_clk == 7'b1100011) begin
            got = {h_l2, h_l1, h_l0};
            want = (sent.size() > 0) ? sent.pop_front() : ~got;
            // R2: recovered word matches the next applied word in order.
            chk(32'(got), 32'(want), "R2", "recovered word");
            n_rx++;
        end
        if (ph == 0) begin
            clk_word = 1'b1;
            m_cap    = shdn_n ? din : '0;
            m_valid  = shdn_n;
        end
        if (ph == 4) clk_word = 1'b0;
        if (ph == 5) din = word_in;
        if (ph == 2) begin
            din    = ~word_in;   // after the word-clock edge: must not be sent (R1)
            shdn_n = shdn_req;
        end
        frame_start = (ph == 3) && strobe_en;
        if (!shdn_n) begin
            pos   = -1;
            m_cur = '0;
            sent.delete();
        end else if (frame_start) begin
            if (m_valid) begin
                pos   = 0;
                m_cur = m_cap;
                sent.push_back(m_cap);
            end else begin
                pos = -1;
            end
        end else if (pos >= 0) begin
            pos = (pos == 6) ? -1 : pos + 1;
        end
        ph = (ph + 1) % 7;
    endtask

    task automatic frames(input int n);
        for (int k = 0; k < n * 7; k++) step();
    endtask

    initial begin
        // R7: reset state, all lanes idle under shutdown.
        cur_req = "R7";
        word_in = 21'h0ABCDE;
        frames(3);
        // R8: release, zeros until a word is sampled and loaded.
        cur_req  = "R8";
        shdn_req = 1'b1;
        frames(2);
        // R3: walking one tells lane mapping apart.
        cur_req = "R3";
        for (int b = 0; b < 21; b++) begin
            word_in = 21'(1) << b;
            frames(1);
        end
        // R4: alternating and solid patterns check bit order in each slice.
        cur_req = "R4";
        word_in = 21'h155555; frames(1);
        word_in = 21'h0AAAAA; frames(1);
        word_in = 21'h1FFFFF; frames(1);
        word_in = 21'h000000; frames(1);
        for (int c = 1; c < 6; c++) begin
            word_in = 21'(c * 21'h010203);
            frames(1);
        end
        // R1: random words; din is complemented after each sampling edge.
        cur_req = "R1";
        for (int r = 0; r < 20; r++) begin
            word_in = 21'($urandom);
            frames(1);
        end
        // R6: strobes withheld, lanes must drain to zero.
        cur_req   = "R6";
        word_in   = 21'h1C3A5F;
        strobe_en = 1'b0;
        frames(3);
        strobe_en = 1'b1;
        frames(2);
        // R7: shutdown in mid-frame, interrupted word never resurfaces.
        cur_req = "R7";
        for (int k = 0; k < 10; k++) step();
        shdn_req = 1'b0;
        frames(2);
        // R8: strobes after release but before a valid word send zeros.
        cur_req  = "R8";
        word_in  = 21'h12F0E1;
        shdn_req = 1'b1;
        frames(3);
        // R2: drain and confirm every loaded word came out.
        cur_req   = "R2";
        strobe_en = 1'b0;
        frames(3);
        chk(32'(sent.size()), 32'd0, "R2", "words left unsent");
        chk(32'(n_rx > 40), 32'd1, "R2", "enough words recovered");
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule